// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Threshold Flags

This block is a first-in first-out buffer with 9-bit words whose write port and read port run on separate, unrelated clocks. Each port has two enables that must both be active for an access. Four active-low status outputs track the fill level: empty, full, and two threshold flags. The threshold flags compare the fill level against two offsets that software can change.

The offsets sit in two 9-bit registers. If the second write enable is held low through reset, the block enters a load mode. In that mode the pin acts as a strobe that redirects a write-port cycle, or a read-port cycle, to the offset registers. Each register moves as two pieces, a low byte and then its top bit. The four pieces follow a fixed rotating order on both ports.

Read data passes through an output register. A three-state stage drives the pins only while output enable is low.

Top module: `pflag_fifo`

## Requirements
- R1: Outside load mode, a rising write-clock edge stores `wdata_i` only when `wr_en1_ni` is low, `wr_en2_ld_i` is high and the buffer is not full. One word is stored per cycle while both enables stay active.
- R2: A rising read-clock edge with `rd_en1_ni` and `rd_en2_ni` both low, on a non-empty buffer, loads the oldest word into the output register, so words leave in write order. On a cycle with no read, the output register keeps its value.
- R3: `full_no` is low while DEPTH words are stored. A write attempted while `full_no` is low is dropped and stored words are not disturbed.
- R4: `empty_no` is low while no word is stored. A read attempted while `empty_no` is low leaves the output register and the buffer contents unchanged.
- R5: While `oe_ni` is high, `rdata_o` is high impedance. While `oe_ni` is low, it shows the output register.
- R6: `afull_no` is low when stored words + m >= DEPTH, where m is the 9-bit almost-full offset, and high otherwise. An offset at or above DEPTH therefore holds it low.
- R7: `aempty_no` is low when stored words <= n, where n is the 9-bit almost-empty offset, and high otherwise. Reset sets both n and m to 7.
- R8: Load mode is selected when `wr_en2_ld_i` is low during reset and at the first write-clock edge after release. In load mode, a write cycle with `wr_en1_ni` low and `wr_en2_ld_i` low writes one offset piece instead of buffer data. The pieces rotate in this order: n[7:0] from `wdata_i[7:0]`, n[8] from `wdata_i[0]`, m[7:0], m[8], and then back to the start. Outside load mode, such a cycle changes nothing.
- R9: In load mode, a read cycle with both read enables low and `wr_en2_ld_i` low loads the next offset piece into the output register, in the same rotating order. The piece is right-aligned and the other bits are zero. Buffer data is not consumed.
- R10: While `rst_ni` is low, the buffer empties. `empty_no` and `aempty_no` go low, `full_no` and `afull_no` go high, and the output register clears to zero.
- R11: The two clocks may be unrelated. Pointers cross between domains in Gray code, changing at most one bit per edge. After traffic stops, all four flags settle to the exact fill level within four edges of each clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk_i | input | 1 | Write clock |
| rclk_i | input | 1 | Read clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en1_ni | input | 1 | Write enable, active low |
| wr_en2_ld_i | input | 1 | Second write enable, active high; offset-access strobe in load mode |
| wdata_i | input | 9 | Write data |
| rd_en1_ni | input | 1 | Read enable, active low |
| rd_en2_ni | input | 1 | Second read enable, active low |
| oe_ni | input | 1 | Output enable, active low |
| rdata_o | output | 9 | Three-state read data |
| empty_no | output | 1 | Empty flag, active low |
| full_no | output | 1 | Full flag, active low |
| aempty_no | output | 1 | Almost-empty flag, active low |
| afull_no | output | 1 | Almost-full flag, active low |

## Verification
The bench builds the block at its default DEPTH of 64 with 9-bit words, using write and read clock periods of 8 and 14 time units so that edge phases drift. At this depth, a few dozen writes reach full and both default thresholds (7 and 57 words). A 9-bit almost-full offset of 256 lies above the depth and holds `afull_no` low even when the buffer is nearly empty. Random traffic with write-heavy and read-heavy phases pushes the flags into and out of full and empty many times while the crossing latency varies.

// File: rtl/pff_pkg.sv
package pff_pkg;

  localparam int unsigned DATA_W  = 9;
  localparam int unsigned LO_W    = 8;
  localparam int unsigned OFS_RST = 7;

  // rotating offset-access slot, shared by both ports
  typedef enum logic [1:0] {
    SEL_AE_LO = 2'd0,
    SEL_AE_HI = 2'd1,
    SEL_AF_LO = 2'd2,
    SEL_AF_HI = 2'd3
  } ofs_sel_e;

  function automatic logic [31:0] bin2gray(logic [31:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [31:0] gray2bin(logic [31:0] g);
    logic [31:0] b;
    b = g;
    for (int i = 1; i < 32; i++) b = b ^ (g >> i);
    return b;
  endfunction

endpackage

// File: rtl/pff_sync.sv
module pff_sync #(
  parameter int unsigned W = 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= '0;
      q_o    <= '0;
    end else begin
      meta_q <= d_i;
      q_o    <= meta_q;
    end
  end
endmodule

// File: rtl/pff_mem.sv
module pff_mem #(
  parameter int unsigned DEPTH = 64,
  parameter int unsigned DW    = 9,
  parameter int unsigned AW    = $clog2(DEPTH)
) (
  input  logic          wclk_i,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [DW-1:0] rdata_o
);
  logic [DW-1:0] ram_q [DEPTH];

  always_ff @(posedge wclk_i) begin
    if (we_i) ram_q[waddr_i] <= wdata_i;
  end

  // slot is stable before its pointer reaches the read side
  assign rdata_o = ram_q[raddr_i];
endmodule

// File: rtl/pff_wr_ctrl.sv
module pff_wr_ctrl
  import pff_pkg::*;
#(
  parameter int unsigned DEPTH = 64,
  parameter int unsigned DW    = 9,
  parameter int unsigned AW    = $clog2(DEPTH)
) (
  input  logic          wclk_i,
  input  logic          rst_ni,
  input  logic          wr_en1_ni,
  input  logic          wr_en2_ld_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [AW:0]   rgray_sync_i,
  output logic          mem_we_o,
  output logic [AW-1:0] mem_waddr_o,
  output logic [DW-1:0] mem_wdata_o,
  output logic [AW:0]   wgray_o,
  output logic [DW-1:0] ae_ofs_o,
  output logic [DW-1:0] af_ofs_o,
  output logic          full_no,
  output logic          afull_no
);
  localparam int unsigned PW   = AW + 1;
  localparam int unsigned CW   = ((PW > DW) ? PW : DW) + 1;
  localparam int unsigned HI_W = DW - LO_W;

  logic          in_rst_q, ld_mode_q;
  logic [PW-1:0] wbin_q, wbin_nxt, rbin_sync, wcnt_nxt;
  logic [DW-1:0] ae_q, af_q;
  ofs_sel_e      wsel_q;
  logic          wr_req, wr_fire, ofs_wr;
  logic          full_q, afull_n_q, afull_nxt;

  // load-mode pin sampled at the first edge after reset release
  always_ff @(posedge wclk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      in_rst_q  <= 1'b1;
      ld_mode_q <= 1'b0;
    end else begin
      in_rst_q <= 1'b0;
      if (in_rst_q) ld_mode_q <= ~wr_en2_ld_i;
    end
  end

  assign wr_req    = ~in_rst_q & ~wr_en1_ni & wr_en2_ld_i;
  assign ofs_wr    = ~in_rst_q & ld_mode_q & ~wr_en1_ni & ~wr_en2_ld_i;
  assign wr_fire   = wr_req & ~full_q;
  assign rbin_sync = PW'(gray2bin(32'(rgray_sync_i)));
  assign wbin_nxt  = wbin_q + PW'(wr_fire);
  assign wcnt_nxt  = wbin_nxt - rbin_sync;
  assign afull_nxt = (CW'(wcnt_nxt) + CW'(af_q)) >= CW'(DEPTH);

  always_ff @(posedge wclk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wbin_q    <= '0;
      wgray_o   <= '0;
      full_q    <= 1'b0;
      afull_n_q <= 1'b1;
    end else begin
      wbin_q    <= wbin_nxt;
      wgray_o   <= PW'(bin2gray(32'(wbin_nxt)));
      full_q    <= (wcnt_nxt == PW'(DEPTH));
      afull_n_q <= ~afull_nxt;
    end
  end

  always_ff @(posedge wclk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ae_q   <= DW'(OFS_RST);
      af_q   <= DW'(OFS_RST);
      wsel_q <= SEL_AE_LO;
    end else if (ofs_wr) begin
      unique case (wsel_q)
        SEL_AE_LO: ae_q[LO_W-1:0] <= wdata_i[LO_W-1:0];
        SEL_AE_HI: ae_q[DW-1:LO_W] <= wdata_i[HI_W-1:0];
        SEL_AF_LO: af_q[LO_W-1:0] <= wdata_i[LO_W-1:0];
        default:   af_q[DW-1:LO_W] <= wdata_i[HI_W-1:0];
      endcase
      wsel_q <= ofs_sel_e'(wsel_q + 2'd1);
    end
  end

  assign mem_we_o    = wr_fire;
  assign mem_waddr_o = wbin_q[AW-1:0];
  assign mem_wdata_o = wdata_i;
  assign ae_ofs_o    = ae_q;
  assign af_ofs_o    = af_q;
  assign full_no     = ~full_q;
  assign afull_no    = afull_n_q;

  a_r3_no_overflow: assert property (@(posedge wclk_i) disable iff (!rst_ni)
    (full_q && wr_req) |=> (wbin_q == $past(wbin_q)));

  a_r3_count_bound: assert property (@(posedge wclk_i) disable iff (!rst_ni)
    (PW'(wbin_q - rbin_sync) <= PW'(DEPTH)));

  a_r11_wgray_step: assert property (@(posedge wclk_i) disable iff (!rst_ni)
    ($countones(wgray_o ^ $past(wgray_o)) <= 1));

  a_r8_sel_advance: assert property (@(posedge wclk_i) disable iff (!rst_ni)
    ofs_wr |=> (wsel_q == ofs_sel_e'($past(wsel_q) + 2'd1)));
endmodule

// File: rtl/pff_rd_ctrl.sv
module pff_rd_ctrl
  import pff_pkg::*;
#(
  parameter int unsigned DEPTH = 64,
  parameter int unsigned DW    = 9,
  parameter int unsigned AW    = $clog2(DEPTH)
) (
  input  logic          rclk_i,
  input  logic          rst_ni,
  input  logic          rd_en1_ni,
  input  logic          rd_en2_ni,
  input  logic          wr_en2_ld_i,
  input  logic [AW:0]   wgray_sync_i,
  input  logic [DW-1:0] mem_rdata_i,
  input  logic [DW-1:0] ae_ofs_i,
  input  logic [DW-1:0] af_ofs_i,
  output logic [AW-1:0] mem_raddr_o,
  output logic [AW:0]   rgray_o,
  output logic [DW-1:0] q_o,
  output logic          empty_no,
  output logic          aempty_no
);
  localparam int unsigned PW   = AW + 1;
  localparam int unsigned CW   = ((PW > DW) ? PW : DW) + 1;
  localparam int unsigned HI_W = DW - LO_W;

  logic          in_rst_q, ld_mode_q;
  logic [PW-1:0] rbin_q, rbin_nxt, wbin_sync, rcnt_nxt;
  logic [DW-1:0] q_q, ofs_piece;
  ofs_sel_e      rsel_q;
  logic          rd_both, ofs_path, ofs_rd, rd_req, rd_fire;
  logic          empty_n_q, aempty_n_q;

  always_ff @(posedge rclk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      in_rst_q  <= 1'b1;
      ld_mode_q <= 1'b0;
    end else begin
      in_rst_q <= 1'b0;
      if (in_rst_q) ld_mode_q <= ~wr_en2_ld_i;
    end
  end

  assign rd_both   = ~in_rst_q & ~rd_en1_ni & ~rd_en2_ni;
  assign ofs_path  = ld_mode_q & ~wr_en2_ld_i;
  assign ofs_rd    = rd_both & ofs_path;
  assign rd_req    = rd_both & ~ofs_path;
  assign rd_fire   = rd_req & empty_n_q;
  assign wbin_sync = PW'(gray2bin(32'(wgray_sync_i)));
  assign rbin_nxt  = rbin_q + PW'(rd_fire);
  assign rcnt_nxt  = wbin_sync - rbin_nxt;

  always_comb begin
    ofs_piece = '0;
    unique case (rsel_q)
      SEL_AE_LO: ofs_piece[LO_W-1:0] = ae_ofs_i[LO_W-1:0];
      SEL_AE_HI: ofs_piece[HI_W-1:0] = ae_ofs_i[DW-1:LO_W];
      SEL_AF_LO: ofs_piece[LO_W-1:0] = af_ofs_i[LO_W-1:0];
      SEL_AF_HI: ofs_piece[HI_W-1:0] = af_ofs_i[DW-1:LO_W];
    endcase
  end

  always_ff @(posedge rclk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rbin_q     <= '0;
      rgray_o    <= '0;
      empty_n_q  <= 1'b0;
      aempty_n_q <= 1'b0;
    end else begin
      rbin_q     <= rbin_nxt;
      rgray_o    <= PW'(bin2gray(32'(rbin_nxt)));
      empty_n_q  <= (rcnt_nxt != '0);
      aempty_n_q <= ~(CW'(rcnt_nxt) <= CW'(ae_ofs_i));
    end
  end

  always_ff @(posedge rclk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      q_q    <= '0;
      rsel_q <= SEL_AE_LO;
    end else if (ofs_rd) begin
      q_q    <= ofs_piece;
      rsel_q <= ofs_sel_e'(rsel_q + 2'd1);
    end else if (rd_fire) begin
      q_q <= mem_rdata_i;
    end
  end

  assign mem_raddr_o = rbin_q[AW-1:0];
  assign q_o         = q_q;
  assign empty_no    = empty_n_q;
  assign aempty_no   = aempty_n_q;

  a_r4_no_underflow: assert property (@(posedge rclk_i) disable iff (!rst_ni)
    (!empty_n_q && rd_req) |=> (rbin_q == $past(rbin_q)));

  a_r4_count_bound: assert property (@(posedge rclk_i) disable iff (!rst_ni)
    (PW'(wbin_sync - rbin_q) <= PW'(DEPTH)));

  a_r11_rgray_step: assert property (@(posedge rclk_i) disable iff (!rst_ni)
    ($countones(rgray_o ^ $past(rgray_o)) <= 1));

  a_r2_q_hold: assert property (@(posedge rclk_i) disable iff (!rst_ni)
    !(rd_fire || ofs_rd) |=> $stable(q_q));

  a_r9_sel_advance: assert property (@(posedge rclk_i) disable iff (!rst_ni)
    ofs_rd |=> (rsel_q == ofs_sel_e'($past(rsel_q) + 2'd1)));
endmodule

// File: rtl/pflag_fifo.sv
module pflag_fifo
  import pff_pkg::*;
#(
  parameter int unsigned DEPTH = 64,
  parameter int unsigned DW    = DATA_W
) (
  input  logic          wclk_i,
  input  logic          rclk_i,
  input  logic          rst_ni,
  input  logic          wr_en1_ni,
  input  logic          wr_en2_ld_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          rd_en1_ni,
  input  logic          rd_en2_ni,
  input  logic          oe_ni,
  output logic [DW-1:0] rdata_o,
  output logic          empty_no,
  output logic          full_no,
  output logic          aempty_no,
  output logic          afull_no
);
  localparam int unsigned AW = $clog2(DEPTH);

  logic          mem_we;
  logic [AW-1:0] mem_waddr, mem_raddr;
  logic [DW-1:0] mem_wdata, mem_rdata;
  logic [AW:0]   wgray, rgray, wgray_sync, rgray_sync;
  logic [DW-1:0] ae_ofs, af_ofs, q;

  pff_wr_ctrl #(.DEPTH(DEPTH), .DW(DW), .AW(AW)) u_wr (
    .wclk_i       (wclk_i),
    .rst_ni       (rst_ni),
    .wr_en1_ni    (wr_en1_ni),
    .wr_en2_ld_i  (wr_en2_ld_i),
    .wdata_i      (wdata_i),
    .rgray_sync_i (rgray_sync),
    .mem_we_o     (mem_we),
    .mem_waddr_o  (mem_waddr),
    .mem_wdata_o  (mem_wdata),
    .wgray_o      (wgray),
    .ae_ofs_o     (ae_ofs),
    .af_ofs_o     (af_ofs),
    .full_no      (full_no),
    .afull_no     (afull_no)
  );

  pff_mem #(.DEPTH(DEPTH), .DW(DW), .AW(AW)) u_mem (
    .wclk_i  (wclk_i),
    .we_i    (mem_we),
    .waddr_i (mem_waddr),
    .wdata_i (mem_wdata),
    .raddr_i (mem_raddr),
    .rdata_o (mem_rdata)
  );

  pff_sync #(.W(AW + 1)) u_sync_w2r (
    .clk_i  (rclk_i),
    .rst_ni (rst_ni),
    .d_i    (wgray),
    .q_o    (wgray_sync)
  );

  pff_sync #(.W(AW + 1)) u_sync_r2w (
    .clk_i  (wclk_i),
    .rst_ni (rst_ni),
    .d_i    (rgray),
    .q_o    (rgray_sync)
  );

  pff_rd_ctrl #(.DEPTH(DEPTH), .DW(DW), .AW(AW)) u_rd (
    .rclk_i       (rclk_i),
    .rst_ni       (rst_ni),
    .rd_en1_ni    (rd_en1_ni),
    .rd_en2_ni    (rd_en2_ni),
    .wr_en2_ld_i  (wr_en2_ld_i),
    .wgray_sync_i (wgray_sync),
    .mem_rdata_i  (mem_rdata),
    .ae_ofs_i     (ae_ofs),
    .af_ofs_i     (af_ofs),
    .mem_raddr_o  (mem_raddr),
    .rgray_o      (rgray),
    .q_o          (q),
    .empty_no     (empty_no),
    .aempty_no    (aempty_no)
  );

  assign rdata_o = oe_ni ? {DW{1'bz}} : q;
endmodule

// File: tb/pflag_fifo_tb.sv
module pflag_fifo_tb;
  localparam int DEPTH = 64;
  localparam int DW    = 9;

  logic          wclk = 1'b0, rclk = 1'b0, rst_ni = 1'b0;
  logic          wr_en1_n = 1'b1, wr_en2_ld = 1'b1;
  logic          rd_en1_n = 1'b1, rd_en2_n = 1'b1, oe_n = 1'b0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata;
  logic          empty_n, full_n, aempty_n, afull_n;

  int n_cmp = 0, n_bad = 0;
  int mq[$];
  int ae_ofs = 7, af_ofs = 7;

  always #4 wclk = ~wclk;  // 125 MHz
  always #7 rclk = ~rclk;

  pflag_fifo #(.DEPTH(DEPTH), .DW(DW)) u_dut (
    .wclk_i(wclk), .rclk_i(rclk), .rst_ni(rst_ni),
    .wr_en1_ni(wr_en1_n), .wr_en2_ld_i(wr_en2_ld), .wdata_i(wdata),
    .rd_en1_ni(rd_en1_n), .rd_en2_ni(rd_en2_n), .oe_ni(oe_n),
    .rdata_o(rdata), .empty_no(empty_n), .full_no(full_n),
    .aempty_no(aempty_n), .afull_no(afull_n)
  );

  task automatic check_eq(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  // expected flags from the model count once both domains have settled
  task automatic chk_flags(input string req);
    int sz;
    repeat (4) @(posedge wclk);
    repeat (4) @(posedge rclk);
    #1;
    sz = mq.size();
    check_eq({req, " R4 empty"}, int'(empty_n), int'(sz != 0));
    check_eq({req, " R3 full"}, int'(full_n), int'(sz != DEPTH));
    check_eq({req, " R7 almost-empty"}, int'(aempty_n), int'(!(sz <= ae_ofs)));
    check_eq({req, " R6 almost-full"}, int'(afull_n), int'(!(sz + af_ofs >= DEPTH)));
  endtask

  task automatic do_reset(input bit load);
    rst_ni    = 1'b0;
    wr_en2_ld = load ? 1'b0 : 1'b1;
    wr_en1_n  = 1'b1;
    rd_en1_n  = 1'b1;
    rd_en2_n  = 1'b1;
    repeat (3) @(posedge wclk);
    repeat (3) @(posedge rclk);
    @(negedge wclk);
    rst_ni = 1'b1;
    repeat (3) @(posedge wclk);
    repeat (3) @(posedge rclk);
    #1;
    wr_en2_ld = 1'b1;
    mq.delete();
    ae_ofs = 7;
    af_ofs = 7;
  endtask

  task automatic write_try(input bit en1, input bit en2, input int d);
    bit fire;
    @(negedge wclk);
    wr_en1_n  = en1;
    wr_en2_ld = en2;
    wdata     = DW'(d);
    fire      = !en1 && en2 && full_n;
    @(posedge wclk);
    #1;
    wr_en1_n  = 1'b1;
    wr_en2_ld = 1'b1;
    if (fire) begin
      if (mq.size() >= DEPTH) check_eq("R3 write accepted while full", mq.size(), DEPTH - 1);
      else mq.push_back(d);
    end
  endtask

  task automatic pop_try(input bit e1, input bit e2);
    bit fire;
    int prev;
    @(negedge rclk);
    rd_en1_n = e1;
    rd_en2_n = e2;
    prev     = int'(rdata);
    fire     = !e1 && !e2 && empty_n;
    @(posedge rclk);
    #1;
    rd_en1_n = 1'b1;
    rd_en2_n = 1'b1;
    if (fire) begin
      if (mq.size() == 0) check_eq("R4 read accepted while empty", 1, 0);
      else check_eq("R2 read data order", int'(rdata), mq.pop_front());
    end else begin
      check_eq("R2 R4 output held without read", int'(rdata), prev);
    end
  endtask

  task automatic ofs_write(input int d);
    @(negedge wclk);
    wr_en1_n  = 1'b0;
    wr_en2_ld = 1'b0;
    wdata     = DW'(d);
    @(posedge wclk);
    #1;
    wr_en1_n  = 1'b1;
    wr_en2_ld = 1'b1;
  endtask

  task automatic ofs_read(input int exp);
    @(negedge rclk);
    wr_en2_ld = 1'b0;
    rd_en1_n  = 1'b0;
    rd_en2_n  = 1'b0;
    @(posedge rclk);
    #1;
    rd_en1_n  = 1'b1;
    rd_en2_n  = 1'b1;
    wr_en2_ld = 1'b1;
    check_eq("R9 offset readback", int'(rdata), exp);
  endtask

  task automatic chk_reset_state();
    check_eq("R10 empty after reset", int'(empty_n), 0);
    check_eq("R10 almost-empty after reset", int'(aempty_n), 0);
    check_eq("R10 full after reset", int'(full_n), 1);
    check_eq("R10 almost-full after reset", int'(afull_n), 1);
    check_eq("R10 output register cleared", int'(rdata), 0);
  endtask

  task automatic fill_to(input int target);
    int guard = 0;
    while (mq.size() < target && guard < 4 * DEPTH) begin
      write_try(1'b0, 1'b1, 'h0A0 + mq.size());
      guard++;
    end
  endtask

  task automatic drain_to(input int target);
    int guard = 0;
    while (mq.size() > target && guard < 8 * DEPTH) begin
      pop_try(1'b0, 1'b0);
      guard++;
    end
  endtask

  task automatic random_phase(input int wr_pct, input int rd_pct, input int n_w, input int n_r);
    fork
      for (int i = 0; i < n_w; i++)
        write_try($urandom_range(0, 99) >= wr_pct, $urandom_range(0, 3) != 0, $urandom_range(0, 511));
      for (int i = 0; i < n_r; i++)
        pop_try($urandom_range(0, 99) >= rd_pct, $urandom_range(0, 4) == 0);
    join
  endtask

  initial begin
    #(200000 * 8);
    n_bad++;
    $display("FAIL watchdog: actual=running expected=finished");
    finish_run();
  end

  initial begin
    void'($urandom(32'd20240611));

    // normal mode
    do_reset(1'b0);
    chk_reset_state();

    // R1: partial enables store nothing; R8: offset-write pattern ignored outside load mode
    write_try(1'b0, 1'b0, 'h0FF);
    write_try(1'b1, 1'b1, 'h011);
    write_try(1'b1, 1'b0, 'h022);
    chk_flags("R1 R8 no store");

    fill_to(7);
    chk_flags("R7 seven words");
    fill_to(8);
    chk_flags("R7 R8 eight words");
    fill_to(56);
    chk_flags("R6 below threshold");
    fill_to(57);
    chk_flags("R6 at threshold");
    fill_to(DEPTH);
    chk_flags("R3 full");
    check_eq("R3 full flag low", int'(full_n), 0);
    write_try(1'b0, 1'b1, 'h1EE);
    chk_flags("R3 write while full dropped");

    drain_to(0);
    chk_flags("R4 drained");
    pop_try(1'b0, 1'b0);
    pop_try(1'b0, 1'b0);

    // R5: last word read was nonzero
    check_eq("R5 driven with oe low", int'(rdata), 'h0A0 + DEPTH - 1);
    oe_n = 1'b1;
    #1;
    check_eq("R5 released with oe high", int'(rdata !== DW'('h0A0 + DEPTH - 1)), 1);
    oe_n = 1'b0;
    #1;
    check_eq("R5 driven again", int'(rdata), 'h0A0 + DEPTH - 1);

    // R11: unrelated clocks, random traffic
    random_phase(70, 60, 500, 280);
    chk_flags("R11 after write-heavy traffic");
    random_phase(30, 85, 400, 300);
    drain_to(0);
    chk_flags("R11 after read-heavy traffic");

    // load mode
    do_reset(1'b1);
    chk_reset_state();
    ofs_read(7);
    ofs_read(0);
    ofs_read(7);
    ofs_read(0);

    ofs_write('h002);
    ofs_write('h001);
    ofs_write('h004);
    ofs_write('h000);
    ae_ofs = 'h102;
    af_ofs = 4;
    ofs_read('h002);
    ofs_read('h001);
    ofs_read('h004);
    ofs_read('h000);
    chk_flags("R8 offsets n=258 m=4");
    fill_to(5);
    chk_flags("R7 wide almost-empty offset");

    ofs_write('h003);
    ofs_write('h000);
    ofs_write('h000);
    ofs_write('h001);
    ae_ofs = 3;
    af_ofs = 'h100;
    ofs_read('h003);
    ofs_read('h000);
    ofs_read('h000);
    ofs_read('h001);
    chk_flags("R6 offset above depth");
    check_eq("R9 offset reads consume no data", mq.size(), 5);

    ofs_write('h003);
    ofs_write('h000);
    ofs_write('h005);
    ofs_write('h000);
    af_ofs = 5;
    fill_to(58);
    chk_flags("R6 load mode below threshold");
    fill_to(59);
    chk_flags("R6 load mode at threshold");
    drain_to(4);
    chk_flags("R7 load mode four words");
    drain_to(3);
    chk_flags("R7 load mode three words");
    drain_to(0);
    chk_flags("R4 load mode drained");

    finish_run();
  end
endmodule